// File: doc/BRIEF.md
# Multi-Ratio Serial-to-Parallel Receiver

This block turns a group of serial receive lanes into parallel words. Each lane is sampled on a fast bit clock. The bit clock runs at a whole multiple of a slow reference clock, and the two are phase aligned, so one bit-clock rising edge falls on every reference rising edge. A two-bit selector chooses the deserialization ratio while the block is running: 8, 7 or 4 bits per reference period, or a 1:1 bypass in which each lane delivers one bit per reference cycle.

Word framing follows the reference clock edge. The serial bit sampled on the bit edge that coincides with a reference edge becomes bit 0 of the word, and the bits sampled on the following bit edges fill the higher positions in order. At the next reference edge the finished words of all lanes move into one output register, with a valid flag beside it.

The selector is read only at reference edges. The word assembled in the first period under a new ratio is marked invalid, because the bit clock is expected to settle during that period. A synchronous reset, seen by both clock domains, clears the outputs.

Top module: `multi_ratio_deser`

## Requirements
- R1: There are LANES lanes (default 16). Lane l's word sits in par_o[8l+7:8l], so in 8:1 mode each reference cycle delivers 128 bits.
- R2: ratio_sel selects the ratio: 0 gives 8:1, 1 gives 7:1, 2 gives 4:1 and 3 gives 1:1. Each reference period contains exactly that many bit-clock rising edges, and the first of them coincides with the reference rising edge.
- R3: In the 8:1, 7:1 and 4:1 modes, bit j of a lane word is the serial bit sampled on bit edge j of the reference period. Edge 0 is the edge that coincides with the reference edge, so the first bit received lands in the LSB.
- R4: In the 7:1 and 4:1 modes, every lane bit at position N or above reads zero. In 1:1 mode, lane bits 7 to 1 read zero.
- R5: In 1:1 mode the bit-clock shift register is bypassed. The serial bit sampled at a reference edge appears as bit 0 of the lane word.
- R6: In every mode, the word of one reference period appears on par_o after the reference edge that closes that period.
- R7: ratio_sel is sampled only at reference rising edges. A change between edges does not alter the framing of the word in progress. While the ratio stays the same, vld_o is high for every reference cycle's word.
- R8: The word assembled in the first reference period under a newly sampled ratio carries vld_o low. This holds for each of two changes on consecutive edges.
- R9: rst is synchronous and is sampled on both clocks. It clears par_o and vld_o. After rst is released, the capture at the first reference edge carries vld_o low, and the word of the first full period is valid.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bit_clk | input | 1 | Fast bit sampling clock, phase aligned to ref_clk |
| ref_clk | input | 1 | Slow reference (word) clock |
| rst | input | 1 | Synchronous reset, active high |
| ratio_sel | input | 2 | Ratio select: 0=8:1, 1=7:1, 2=4:1, 3=1:1 |
| ser_i | input | LANES | Serial data, one bit per lane |
| par_o | output | LANES*8 | Parallel words, lane l in bits [8l+7:8l] |
| vld_o | output | 1 | Word valid, in the reference clock domain |

## Verification
The hardest case to reach from the ports is a ratio change. The bit-clock rate must switch on exactly the reference edge that samples the new selector, and the framing and the valid flag must follow across that boundary. Changes on two consecutive edges make this harder still. The bench's clock generator reads ratio_sel at the start of every reference period, so the number of bit edges per period always matches what the design latches. A directed run at the start walks through every ratio and then changes the ratio twice in a row. After that, random ratio changes are applied between edges, together with bit patterns that mark the LSB and MSB positions and a reset in the middle of the run.

// File: rtl/multi_ratio_deser.sv
`timescale 1ns/1ps
module multi_ratio_deser #(
  parameter int LANES = 16
) (
  input  logic               bit_clk,
  input  logic               ref_clk,
  input  logic               rst,
  input  logic [1:0]         ratio_sel,
  input  logic [LANES-1:0]   ser_i,
  output logic [LANES*8-1:0] par_o,
  output logic               vld_o
);
  localparam int WORD = 8;
  localparam int CW   = $clog2(WORD) + 1;
  localparam logic [1:0] SEL_8 = 2'd0, SEL_7 = 2'd1, SEL_4 = 2'd2, SEL_1 = 2'd3;

  function automatic logic [CW-1:0] span(input logic [1:0] s);
    case (s)
      SEL_8:   return CW'(8);
      SEL_7:   return CW'(7);
      SEL_4:   return CW'(4);
      default: return CW'(1);
    endcase
  endfunction

  logic [WORD-1:0]       shreg [LANES];
  logic [LANES-1:0]      byp_q;
  logic [1:0]            sel_q;
  logic                  sel_chg;
  logic                  ref_tog, tog_seen, armed, mark;
  logic [CW-1:0]         edge_cnt;
  logic [LANES*WORD-1:0] nxt;

  // bit clock domain: free-running LSB-first shift per lane
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge bit_clk)
      if (rst) shreg[g] <= '0;
      else     shreg[g] <= {ser_i[g], shreg[g][WORD-1:1]};

    assign nxt[g*WORD +: WORD] = (sel_q == SEL_1) ? {{(WORD-1){1'b0}}, byp_q[g]}
                                                  : shreg[g] >> (WORD - int'(span(sel_q)));
  end

  // word boundary counter: bit edges between reference edges
  assign mark = ref_tog != tog_seen;

  always_ff @(posedge bit_clk)
    if (rst) begin
      tog_seen <= 1'b0;
      armed    <= 1'b0;
      edge_cnt <= '0;
    end else begin
      tog_seen <= ref_tog;
      if (mark) begin
        armed    <= 1'b1;
        edge_cnt <= CW'(1);
      end else if (edge_cnt != '1) begin
        edge_cnt <= edge_cnt + 1'b1;
      end
    end

  // reference clock domain: ratio latch, bypass sample, word capture
  always_ff @(posedge ref_clk)
    if (rst) begin
      sel_q   <= ratio_sel;
      sel_chg <= 1'b1;
      ref_tog <= 1'b0;
      byp_q   <= '0;
      vld_o   <= 1'b0;
      par_o   <= '0;
    end else begin
      sel_q   <= ratio_sel;
      sel_chg <= ratio_sel != sel_q;
      ref_tog <= ~ref_tog;
      byp_q   <= ser_i;
      vld_o   <= ~sel_chg;
      par_o   <= nxt;
    end

  function automatic logic upper_clear(input logic [LANES*WORD-1:0] v, input logic [1:0] s);
    logic ok = 1'b1;
    for (int l = 0; l < LANES; l++)
      if ((v[l*WORD +: WORD] >> span(s)) != '0) ok = 1'b0;
    return ok;
  endfunction

  function automatic logic [LANES-1:0] lane_lsbs(input logic [LANES*WORD-1:0] v);
    logic [LANES-1:0] r;
    for (int l = 0; l < LANES; l++) r[l] = v[l*WORD];
    return r;
  endfunction

  AST_WORD_SPAN: assert property (@(posedge bit_clk) disable iff (rst)
    (mark && armed && !sel_chg) |-> edge_cnt == span(sel_q)); // R2

  AST_CHANGE_DROPS_WORD: assert property (@(posedge ref_clk) disable iff (rst)
    (sel_q != $past(sel_q)) |=> !vld_o); // R8

  AST_UPPER_ZERO: assert property (@(posedge ref_clk) disable iff (rst)
    vld_o |-> upper_clear(par_o, $past(sel_q))); // R4

  AST_BYPASS_PATH: assert property (@(posedge ref_clk) disable iff (rst)
    ($past(sel_q) == SEL_1 && !$past(rst) && !$past(rst, 2))
      |-> lane_lsbs(par_o) == $past(ser_i, 2)); // R5
endmodule

// File: tb/multi_ratio_deser_tb_top.sv
`timescale 1ns/1ps
module multi_ratio_deser_tb_top;
  localparam int LANES = 16;
  localparam int WORD  = 8;
  localparam int NPER  = 1500;

  logic bit_clk = 1'b0, ref_clk = 1'b0, rst = 1'b1;
  logic [1:0] ratio_sel = 2'd0;
  logic [LANES-1:0] ser_i = '0;
  logic [LANES*WORD-1:0] par_o;
  logic vld_o;

  int checks = 0, fails = 0;
  bit done = 1'b0;
  logic [WORD-1:0] cur [LANES];
  logic [WORD-1:0] h1  [LANES];
  logic [WORD-1:0] h2  [LANES];
  int m0, m1, m2, m3;
  bit rs0, rs1, rs2;

  multi_ratio_deser #(.LANES(LANES)) dut_i (
    .bit_clk(bit_clk), .ref_clk(ref_clk), .rst(rst), .ratio_sel(ratio_sel),
    .ser_i(ser_i), .par_o(par_o), .vld_o(vld_o)
  );

  function automatic int ratio_of(int m);
    case (m)
      0: return 8;
      1: return 7;
      2: return 4;
      default: return 1;
    endcase
  endfunction

  function automatic string tag_of(int m);
    case (m)
      0: return "R1 R2 R3 R6 8:1";
      1: return "R2 R3 R4 R6 7:1";
      2: return "R2 R3 R4 R6 4:1";
      default: return "R2 R5 R6 1:1";
    endcase
  endfunction

  function automatic logic [LANES*WORD-1:0] expect_word(int m);
    logic [LANES*WORD-1:0] e;
    int mask = (1 << ratio_of(m)) - 1;
    for (int l = 0; l < LANES; l++)
      e[l*WORD +: WORD] = h2[l] & WORD'(mask);
    return e;
  endfunction

  function automatic int dir_mode(int p);
    if (p < 6)  return 0;
    if (p < 10) return 1;
    if (p < 14) return 2;
    if (p < 18) return 3;
    case (p)
      18: return 0;
      19: return 3;
      20: return 3;
      21: return 2;
      22: return 1;
      default: return 0;
    endcase
  endfunction

  task automatic chk_bit(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s vld_o actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic chk_vec(input logic [LANES*WORD-1:0] act, input logic [LANES*WORD-1:0] exp,
                         input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s par_o actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  initial begin
    int nxt_mode, r;
    void'($urandom(32'h1f2e3d4c));
    m0 = 0; m1 = 0; m2 = 0; m3 = 0;
    rs0 = 1'b1; rs1 = 1'b1; rs2 = 1'b1;
    for (int l = 0; l < LANES; l++) begin cur[l] = '0; h1[l] = '0; h2[l] = '0; end

    for (int p = 0; p < NPER; p++) begin
      rs2 = rs1; rs1 = rs0;
      rs0 = (p < 3) || (p >= 900 && p < 903);
      m3 = m2; m2 = m1; m1 = m0; m0 = int'(ratio_sel);
      for (int l = 0; l < LANES; l++) begin h2[l] = h1[l]; h1[l] = cur[l]; end
      rst = rs0;

      // outputs now hold the capture from the previous reference edge
      if (p > 0) begin
        if (rs1) begin
          chk_bit(vld_o, 1'b0, "R9 reset");
          chk_vec(par_o, '0, "R9 reset");
        end else if (rs2) begin
          chk_bit(vld_o, 1'b0, "R9 first capture after release");
        end else if (m2 == m3) begin
          chk_bit(vld_o, 1'b1, "R7 steady ratio");
          chk_vec(par_o, expect_word(m2), tag_of(m2));
        end else begin
          chk_bit(vld_o, 1'b0, "R8 first word after ratio change");
        end
      end

      for (int l = 0; l < LANES; l++) begin
        case (p % 64)
          20: cur[l] = 8'hFF;
          21: cur[l] = 8'h80;
          22: cur[l] = 8'h01;
          23: cur[l] = (l % 2 == 0) ? 8'h55 : 8'hAA;
          default: cur[l] = WORD'($urandom);
        endcase
      end

      if (p < 23) nxt_mode = dir_mode(p + 1);
      else nxt_mode = ($urandom % 5 == 0) ? int'($urandom % 4) : m0;

      r = ratio_of(m0);
      for (int k = 0; k < r; k++) begin
        for (int l = 0; l < LANES; l++) ser_i[l] = cur[l][k];
        #2;
        bit_clk = 1'b1;
        if (k == 0) ref_clk = 1'b1;
        #2;
        bit_clk = 1'b0;
        if (k == (r - 1) / 2) ref_clk = 1'b0;
        if (k == 0) ratio_sel = 2'(nxt_mode);
      end
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired at %0t", $time);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule